// File: doc/BRIEF.md
# Transmit Trigger Gating Unit

This block sits in the transmit path of one radio channel and applies a trigger-active flag to the sample stream. It offers two places to gate. In output gating the samples keep flowing at full rate. Every sample that arrives while the trigger is inactive is sent on as zero, so the running sample count keeps advancing and the stream stays phase coherent. In DSP gating the unit stops samples before they reach the processing chain. While the trigger is inactive nothing is sent on and the sample counter is frozen. This lets a burst of samples be held upstream and released by the trigger.

In DSP gating a drop-enable bit chooses what happens to input that arrives while the trigger is inactive. When the bit is low, the unit back-pressures the input by holding ready low. When the bit is high, it accepts the input and discards it. Input and output use valid/ready handshakes. The output is held in one register stage. A new gating mode is adopted only while that stage is empty, so a sample is never split across a mode change.

Top module: `tx_trig_gate`

## Requirements
- R1: After synchronous reset: the gating mode is output gating, out_valid is 0, sample_count is 0 and in_ready is 1.
- R2: Output gating with trig_active=1: each accepted sample appears unchanged on out_data with out_valid=1 in the cycle after acceptance.
- R3: Output gating with trig_active=0: each accepted sample still produces one output sample, but its out_data is all zeros.
- R4: sample_count (64 bits) increases by exactly one on every clock edge with out_valid=1 and out_ready=1, and otherwise holds its value.
- R5: DSP gating (gate_mode=1) with trig_active=0 and drop_en=0: in_ready is 0, no new output sample is produced and sample_count stays frozen.
- R6: DSP gating with trig_active=0 and drop_en=1: in_ready is 1, accepted samples are discarded (out_valid stays 0) and sample_count stays frozen.
- R7: DSP gating with trig_active=1: samples pass unchanged, with the same one-cycle latency as in R2.
- R8: While out_valid=1 and out_ready=0, out_valid and out_data hold their values.
- R9: A new value of gate_mode (0 = output gating, 1 = DSP gating) takes effect only after a clock edge at which the output register was empty. While a sample is held in the output register, the previous mode stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_active | input | 1 | Trigger flag, 1 = active |
| gate_mode | input | 1 | Gating point: 0 = output gating, 1 = DSP gating |
| drop_en | input | 1 | DSP gating while inactive: 1 = discard input, 0 = stall input |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | DATA_W | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Output sample |
| sample_count | output | CNT_W | Running count of output handshakes |

## Verification
The bench drives the same kind of sample under each gating mode with the trigger held active and inactive. This separates zero-blanking with the count running (output gating) from the frozen-count cases in DSP gating. It also checks DSP gating with drop_en low and high to tell stalling apart from discarding: one is seen through in_ready, the other through an output that stays empty. A sample is held under back-pressure while gate_mode flips, which shows that the old mode still decides the next accepted sample and that the new mode takes over only after the register drains.

// File: rtl/tx_gate_pkg.sv
package tx_gate_pkg;
    typedef enum logic {
        GATE_OUTPUT = 1'b0,
        GATE_DSP    = 1'b1
    } gate_mode_e;

    typedef struct packed {
        logic ready;
        logic load;
        logic blank;
    } gate_decision_t;

    function automatic gate_decision_t decide(gate_mode_e mode, logic active,
                                              logic drop, logic valid, logic room);
        gate_decision_t d;
        d.ready = room;
        d.load  = valid & room;
        d.blank = 1'b0;
        if (mode == GATE_OUTPUT) begin
            d.blank = ~active;
        end else if (!active) begin
            d.ready = drop;
            d.load  = 1'b0;
        end
        return d;
    endfunction
endpackage

// File: rtl/tx_gate_policy.sv
module tx_gate_policy
    import tx_gate_pkg::*;
(
    input  gate_mode_e     mode,
    input  logic           trig_active,
    input  logic           drop_en,
    input  logic           in_valid,
    input  logic           room,
    output gate_decision_t dec
);
    always_comb dec = decide(mode, trig_active, drop_en, in_valid, room);
endmodule

// File: rtl/tx_gate_stage.sv
module tx_gate_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              blank,
    input  logic [DATA_W-1:0] in_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              room
);
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    assign room      = ~vld_q | out_ready;
    assign out_valid = vld_q;
    assign out_data  = dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else if (room) begin
            vld_q <= load;
            if (load) dat_q <= blank ? '0 : in_data;
        end
    end
endmodule

// File: rtl/tx_gate_counter.sv
module tx_gate_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + ONE;
    end
endmodule

// File: rtl/tx_trig_gate.sv
module tx_trig_gate
    import tx_gate_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_active,
    input  logic              gate_mode,
    input  logic              drop_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [CNT_W-1:0]  sample_count
);
    gate_mode_e     mode_q;
    gate_decision_t dec;
    logic           room;

    always_ff @(posedge clk) begin
        if (rst)             mode_q <= GATE_OUTPUT;
        else if (!out_valid) mode_q <= gate_mode_e'(gate_mode);
    end

    tx_gate_policy u_policy (
        .mode(mode_q), .trig_active(trig_active), .drop_en(drop_en),
        .in_valid(in_valid), .room(room), .dec(dec)
    );

    assign in_ready = dec.ready;

    tx_gate_stage #(.DATA_W(DATA_W)) u_stage (
        .clk(clk), .rst(rst), .load(dec.load), .blank(dec.blank),
        .in_data(in_data), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .room(room)
    );

    tx_gate_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .inc(out_valid & out_ready), .count(sample_count)
    );
endmodule

// File: rtl/tx_trig_gate_chk.sv
module tx_trig_gate_chk
    import tx_gate_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_active,
    input  logic              drop_en,
    input  logic              in_ready,
    input  logic              out_valid,
    input  logic              out_ready,
    input  logic [DATA_W-1:0] out_data,
    input  logic [CNT_W-1:0]  sample_count,
    input  gate_mode_e        mode_q
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (mode_q == GATE_OUTPUT && !out_valid && sample_count == '0)); // R1
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> sample_count == $past(sample_count) + CNT_W'(1)); // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready) |=> $stable(sample_count)); // R4
    AST_DSP_STALL: assert property (@(posedge clk) disable iff (rst)
        (mode_q == GATE_DSP && !trig_active && !drop_en) |-> !in_ready); // R5
    AST_DSP_DROP: assert property (@(posedge clk) disable iff (rst)
        (mode_q == GATE_DSP && !trig_active && drop_en) |-> in_ready); // R6
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
    AST_MODE_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> $stable(mode_q)); // R9
endmodule

bind tx_trig_gate tx_trig_gate_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .trig_active(trig_active), .drop_en(drop_en),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .sample_count(sample_count), .mode_q(mode_q)
);

// File: tb/tx_trig_gate_tb.sv
module tx_trig_gate_tb;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 64;

    logic              clk = 1'b0;
    logic              rst;
    logic              trig_active, gate_mode, drop_en, in_valid, out_ready;
    logic [DATA_W-1:0] in_data;
    logic              in_ready, out_valid;
    logic [DATA_W-1:0] out_data;
    logic [CNT_W-1:0]  sample_count;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tx_trig_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .trig_active(trig_active), .gate_mode(gate_mode),
        .drop_en(drop_en), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .sample_count(sample_count)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain();
        in_valid  = 1'b0;
        out_ready = 1'b1;
        step();
        step();
    endtask

    task automatic t_reset();
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 count", sample_count, 64'd0);
        check("R1 in_ready", 64'(in_ready), 64'd1);
    endtask

    task automatic t_out_active();
        logic [63:0] base = sample_count;
        gate_mode = 1'b0; trig_active = 1'b1;
        in_valid = 1'b1; in_data = 16'h1234;
        step();
        in_valid = 1'b0;
        check("R2 valid", 64'(out_valid), 64'd1);
        check("R2 data", 64'(out_data), 64'h1234);
        check("R4 count before handshake", sample_count, base);
        step();
        check("R4 count after handshake", sample_count, base + 1);
        check("R2 empty", 64'(out_valid), 64'd0);
    endtask

    task automatic t_out_blank();
        logic [63:0] base = sample_count;
        trig_active = 1'b0;
        in_valid = 1'b1; in_data = 16'hBEEF;
        step();
        check("R3 valid", 64'(out_valid), 64'd1);
        check("R3 zero data", 64'(out_data), 64'd0);
        in_data = 16'h00F1;
        step();
        in_valid = 1'b0;
        check("R3 second zero", 64'(out_data), 64'd0);
        step();
        check("R4 count runs while blanked", sample_count, base + 2);
    endtask

    task automatic t_dsp();
        logic [63:0] base;
        gate_mode = 1'b1; drop_en = 1'b1; trig_active = 1'b0;
        step();
        base = sample_count;
        in_valid = 1'b1; in_data = 16'h0A0A;
        #1;
        check("R6 in_ready", 64'(in_ready), 64'd1);
        step();
        step();
        check("R6 no output", 64'(out_valid), 64'd0);
        check("R6 count frozen", sample_count, base);
        drop_en = 1'b0;
        #1;
        check("R5 in_ready low", 64'(in_ready), 64'd0);
        step();
        check("R5 no output", 64'(out_valid), 64'd0);
        check("R5 count frozen", sample_count, base);
        trig_active = 1'b1; in_data = 16'h5A5A;
        step();
        in_valid = 1'b0;
        check("R7 valid", 64'(out_valid), 64'd1);
        check("R7 data", 64'(out_data), 64'h5A5A);
        step();
        check("R7 count", sample_count, base + 1);
    endtask

    task automatic t_boundary();
        gate_mode = 1'b0; trig_active = 1'b1; drop_en = 1'b0;
        drain();
        out_ready = 1'b0;
        in_valid = 1'b1; in_data = 16'hC0DE;
        step();
        in_valid = 1'b0;
        gate_mode = 1'b1; trig_active = 1'b0;
        step();
        step();
        check("R8 held valid", 64'(out_valid), 64'd1);
        check("R8 held data", 64'(out_data), 64'hC0DE);
        out_ready = 1'b1;
        in_valid = 1'b1; in_data = 16'h7777;
        #1;
        check("R9 old mode in_ready", 64'(in_ready), 64'd1);
        step();
        in_valid = 1'b0;
        check("R9 old mode blanks", 64'(out_data), 64'd0);
        check("R9 old mode valid", 64'(out_valid), 64'd1);
        step();
        step();
        in_valid = 1'b1;
        #1;
        check("R9 new mode stalls", 64'(in_ready), 64'd0);
        in_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; trig_active = 1'b0; gate_mode = 1'b0; drop_en = 1'b0;
        in_valid = 1'b0; out_ready = 1'b1; in_data = '0;
        step();
        step();
        rst = 1'b0;
        t_reset();
        step();
        t_out_active();
        t_out_blank();
        t_dsp();
        t_boundary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule